// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit owns the two length registers of a vector pipeline: the active vector length (VL) and the ceiling it runs against (MVL). A 12-bit length-control field, lifted by the front end from a long instruction prefix, arrives together with a valid strobe. The unit classifies that field into one of six update modes, computes the new register pair, and asks the scalar register file to record the resulting VL in a destination register.

The modes are: HOLD (all-zero field, nothing happens), LOOP_IMM (VL from an immediate), LOOP_REG (VL from a scalar register, capped at MVL), ONE_OFF (MVL and VL both set from an immediate), MAX_ONLY (MVL set from an immediate, VL shrunk to fit), and BAD (a loop-mode register source of index zero, reported as an illegal instruction). The register pair is the unit's only state. On each accepted request it moves from its present value to the value the mode selects, and it keeps that value when the strobe is low.

The source register index is passed out combinationally so the register file can return its value in the same cycle. Results, the write-back request and the illegal flag all appear on the cycle after the clock edge that accepted the strobe.

Top module: `vl_set_unit`

## Requirements
- R1: While reset is asserted and after its release, VL and MVL both read 1, and the write-back request and the illegal flag are low.
- R2: A request whose 12-bit field is entirely zero (HOLD) changes neither VL nor MVL and raises no write-back.
- R3: With field bit 11 = 0 and bit 0 = 0 (LOOP_IMM), VL becomes the 5-bit value in bits 5:1 plus one, even if that exceeds MVL, and MVL is unchanged; an immediate of 0 gives VL = 1.
- R4: With bit 11 = 0, bit 0 = 1 and bits 5:1 nonzero (LOOP_REG), VL becomes the full-width scalar source value if it is no larger than MVL and MVL otherwise; MVL is unchanged, and the source index output always equals bits 5:1 of the field.
- R5: With bit 11 = 0, bit 0 = 1 and bits 5:1 equal to zero (BAD), the illegal flag pulses for one cycle, VL and MVL are unchanged and no write-back is requested.
- R6: With bit 11 = 1 and bit 0 = 0 (ONE_OFF), MVL and VL both become bits 5:1 plus one.
- R7: With bit 11 = 1 and bit 0 = 1 (MAX_ONLY), MVL becomes bits 5:1 plus one and VL becomes the smaller of its old value and the new MVL.
- R8: In LOOP_IMM, LOOP_REG, ONE_OFF and MAX_ONLY, a one-cycle write-back request carries index bits 10:6 and the new VL zero-extended to the scalar width, unless that index is zero, in which case no request is made.
- R9: Updates take effect on the clock edge that samples the strobe high; with the strobe low, VL and MVL hold and both pulse outputs stay low whatever the field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Length-control request strobe |
| len_ctrl | input | 12 | Length-control field |
| src_value | input | XLEN | Value of the scalar register named by src_idx |
| src_idx | output | 5 | Scalar source register index (field bits 5:1) |
| vl_o | output | VL_W | Current vector length |
| mvl_o | output | VL_W | Current maximum vector length |
| wb_req | output | 1 | Scalar write-back request pulse |
| wb_idx | output | 5 | Scalar write-back register index |
| wb_data | output | XLEN | Scalar write-back value (new VL) |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The bench targets a register-supplied length whose upper bits are set while its low bits are small. A design that truncated before comparing would load the small value instead of capping at MVL. It also lowers MVL beneath the current VL, where a design that forgot the clamp would leave VL above its ceiling. It raises MVL above VL, where a design that clamped upward would wrongly grow VL. A loop-mode immediate larger than MVL is checked to load unchanged. A zero-index register source must flag illegal without touching state or writing back. A nonzero field with an all-zero immediate must not be mistaken for the all-zero HOLD field. Destination index zero must suppress the write-back in every mode.

// File: rtl/vl_set_pkg.sv
package vl_set_pkg;

    localparam int CTRL_W = 12;
    localparam int IDX_W  = 5;

    typedef enum logic [2:0] {
        M_HOLD     = 3'd0,
        M_LOOP_IMM = 3'd1,
        M_LOOP_REG = 3'd2,
        M_ONE_OFF  = 3'd3,
        M_MAX_ONLY = 3'd4,
        M_BAD      = 3'd5
    } len_mode_e;

    typedef struct packed {
        len_mode_e        mode;
        logic [IDX_W-1:0] imm;
        logic [IDX_W-1:0] dst;
    } len_cmd_t;

endpackage

// File: rtl/vl_set_decode.sv
module vl_set_decode
    import vl_set_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output len_cmd_t          cmd
);
    // Field slices: bit 11 selects one-off vs loop, bit 0 is the sub-select,
    // bits 10:6 name the destination, bits 5:1 carry immediate or source index.
    logic             sel_hi;
    logic             sel_lo;
    logic [IDX_W-1:0] mid;

    always_comb begin
        sel_hi   = ctrl[11];
        sel_lo   = ctrl[0];
        mid      = ctrl[5:1];
        cmd.imm  = mid;
        cmd.dst  = ctrl[10:6];
        if (ctrl == '0) begin
            cmd.mode = M_HOLD;
        end else if (!sel_hi && !sel_lo) begin
            cmd.mode = M_LOOP_IMM;
        end else if (!sel_hi && sel_lo) begin
            cmd.mode = (mid == '0) ? M_BAD : M_LOOP_REG;
        end else if (sel_hi && !sel_lo) begin
            cmd.mode = M_ONE_OFF;
        end else begin
            cmd.mode = M_MAX_ONLY;
        end
    end
endmodule

// File: rtl/vl_set_next.sv
module vl_set_next
    import vl_set_pkg::*;
#(
    parameter int VL_W = 6,
    parameter int XLEN = 64
) (
    input  len_cmd_t         cmd,
    input  logic [XLEN-1:0]  src_value,
    input  logic [VL_W-1:0]  vl_cur,
    input  logic [VL_W-1:0]  mvl_cur,
    output logic [VL_W-1:0]  vl_nxt,
    output logic [VL_W-1:0]  mvl_nxt,
    output logic             writes_vl,
    output logic             bad_op
);
    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    logic [VL_W-1:0] imm_len;
    logic [XLEN-1:0] mvl_wide;
    logic [VL_W-1:0] src_capped;
    logic [VL_W-1:0] vl_fit;

    always_comb begin
        imm_len    = VL_W'(cmd.imm) + ONE;
        mvl_wide   = XLEN'(mvl_cur);
        src_capped = (src_value > mvl_wide) ? mvl_cur : src_value[VL_W-1:0];
        vl_fit     = (vl_cur > imm_len) ? imm_len : vl_cur;
    end

    always_comb begin
        vl_nxt    = vl_cur;
        mvl_nxt   = mvl_cur;
        writes_vl = 1'b0;
        bad_op    = 1'b0;
        unique case (cmd.mode)
            M_HOLD: begin
            end
            M_LOOP_IMM: begin
                vl_nxt    = imm_len;
                writes_vl = 1'b1;
            end
            M_LOOP_REG: begin
                vl_nxt    = src_capped;
                writes_vl = 1'b1;
            end
            M_ONE_OFF: begin
                vl_nxt    = imm_len;
                mvl_nxt   = imm_len;
                writes_vl = 1'b1;
            end
            M_MAX_ONLY: begin
                mvl_nxt   = imm_len;
                vl_nxt    = vl_fit;
                writes_vl = 1'b1;
            end
            M_BAD: begin
                bad_op = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit
    import vl_set_pkg::*;
#(
    parameter int VL_W = 6,
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [11:0]      len_ctrl,
    input  logic [XLEN-1:0]  src_value,
    output logic [4:0]       src_idx,
    output logic [VL_W-1:0]  vl_o,
    output logic [VL_W-1:0]  mvl_o,
    output logic             wb_req,
    output logic [4:0]       wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             illegal
);
    localparam logic [VL_W-1:0] RST_LEN = VL_W'(1);
    localparam int              PAD_W   = XLEN - VL_W;

    len_cmd_t        cmd;
    logic [VL_W-1:0] vl_nxt;
    logic [VL_W-1:0] mvl_nxt;
    logic            writes_vl;
    logic            bad_op;

    logic [VL_W-1:0] vl_q,  mvl_q;
    logic            wb_q,  ill_q;
    logic [4:0]      wbi_q;

    vl_set_decode u_dec (
        .ctrl (len_ctrl),
        .cmd  (cmd)
    );

    vl_set_next #(.VL_W(VL_W), .XLEN(XLEN)) u_nxt (
        .cmd       (cmd),
        .src_value (src_value),
        .vl_cur    (vl_q),
        .mvl_cur   (mvl_q),
        .vl_nxt    (vl_nxt),
        .mvl_nxt   (mvl_nxt),
        .writes_vl (writes_vl),
        .bad_op    (bad_op)
    );

    // Length state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q  <= RST_LEN;
            mvl_q <= RST_LEN;
        end else if (req_valid) begin
            vl_q  <= vl_nxt;
            mvl_q <= mvl_nxt;
        end
    end

    // Pulse outputs register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q  <= 1'b0;
            ill_q <= 1'b0;
            wbi_q <= '0;
        end else begin
            wb_q  <= req_valid && writes_vl && (cmd.dst != '0);
            ill_q <= req_valid && bad_op;
            wbi_q <= cmd.dst;
        end
    end

    always_comb begin
        src_idx = len_ctrl[5:1];
        vl_o    = vl_q;
        mvl_o   = mvl_q;
        wb_req  = wb_q;
        wb_idx  = wbi_q;
        wb_data = {{PAD_W{1'b0}}, vl_q};
        illegal = ill_q;
    end

    a_r2_hold_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && len_ctrl == 12'd0) |=> ($stable(vl_o) && $stable(mvl_o) && !wb_req && !illegal));

    a_r4_reg_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !len_ctrl[11] && len_ctrl[0] && len_ctrl[5:1] != 5'd0)
        |=> (vl_o <= mvl_o && $stable(mvl_o)));

    a_r5_bad_src: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !len_ctrl[11] && len_ctrl[0] && len_ctrl[5:1] == 5'd0)
        |=> (illegal && !wb_req && $stable(vl_o) && $stable(mvl_o)));

    a_r6_one_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && len_ctrl[11] && !len_ctrl[0])
        |=> (vl_o == mvl_o && 32'(mvl_o) == 32'($past(len_ctrl[5:1])) + 32'd1));

    a_r7_max_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && len_ctrl[11] && len_ctrl[0])
        |=> (vl_o <= mvl_o && vl_o <= $past(vl_o)));

    a_r8_wb_shape: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_idx != 5'd0 && wb_data == {{PAD_W{1'b0}}, vl_o}));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wb_req && !illegal && $stable(vl_o) && $stable(mvl_o)));

    a_r5_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && illegal));

endmodule

// File: tb/vl_set_unit_tb.sv
`timescale 1ns/1ps
module vl_set_unit_tb;

    localparam int VL_W = 6;
    localparam int XLEN = 64;
    localparam int NV   = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     len_ctrl = '0;
    logic [XLEN-1:0] src_value = '0;
    logic [4:0]      src_idx;
    logic [VL_W-1:0] vl_o, mvl_o;
    logic            wb_req;
    logic [4:0]      wb_idx;
    logic [XLEN-1:0] wb_data;
    logic            illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    vl_set_unit #(.VL_W(VL_W), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .len_ctrl(len_ctrl),
        .src_value(src_value), .src_idx(src_idx), .vl_o(vl_o), .mvl_o(mvl_o),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
    );

    // {ctrl[12], src[16], exp_vl[6], exp_mvl[6], exp_wb, exp_idx[5], exp_ill}
    localparam logic [46:0] VEC [NV] = '{
        {1'b1, 5'd3,  5'd7,  1'b0, 16'd0,   6'd8,  6'd8,  1'b1, 5'd3,  1'b0}, // R6 one-off
        {1'b0, 5'd0,  5'd2,  1'b0, 16'd0,   6'd3,  6'd8,  1'b0, 5'd0,  1'b0}, // R3 loop imm, no wb
        {1'b0, 5'd9,  5'd4,  1'b1, 16'd5,   6'd5,  6'd8,  1'b1, 5'd9,  1'b0}, // R4 reg below MVL
        {1'b0, 5'd9,  5'd4,  1'b1, 16'd100, 6'd8,  6'd8,  1'b1, 5'd9,  1'b0}, // R4 reg clamped
        {1'b1, 5'd2,  5'd3,  1'b1, 16'd0,   6'd4,  6'd4,  1'b1, 5'd2,  1'b0}, // R7 VL shrinks
        {1'b1, 5'd0,  5'd15, 1'b1, 16'd0,   6'd4,  6'd16, 1'b0, 5'd0,  1'b0}, // R7 VL kept
        {1'b0, 5'd5,  5'd0,  1'b1, 16'd9,   6'd4,  6'd16, 1'b0, 5'd0,  1'b1}, // R5 illegal
        {1'b0, 5'd0,  5'd0,  1'b0, 16'd9,   6'd4,  6'd16, 1'b0, 5'd0,  1'b0}, // R2 hold
        {1'b0, 5'd31, 5'd0,  1'b0, 16'd0,   6'd1,  6'd16, 1'b1, 5'd31, 1'b0}, // R3 imm 0
        {1'b0, 5'd1,  5'd31, 1'b0, 16'd0,   6'd32, 6'd16, 1'b1, 5'd1,  1'b0}, // R3 above MVL
        {1'b1, 5'd0,  5'd31, 1'b0, 16'd0,   6'd32, 6'd32, 1'b0, 5'd0,  1'b0}, // R6 max imm
        {1'b0, 5'd6,  5'd31, 1'b1, 16'd0,   6'd0,  6'd32, 1'b1, 5'd6,  1'b0}, // R4 zero src
        {1'b1, 5'd7,  5'd0,  1'b1, 16'd0,   6'd0,  6'd1,  1'b1, 5'd7,  1'b0}, // R7 imm 0
        {1'b1, 5'd0,  5'd0,  1'b0, 16'd0,   6'd1,  6'd1,  1'b0, 5'd0,  1'b0}  // R6 imm 0
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [11:0] c, input logic [XLEN-1:0] s, input logic v);
        @(negedge clk);
        len_ctrl  = c;
        src_value = s;
        req_valid = v;
        #1;
        chk("R4 src_idx", 64'(src_idx), 64'(c[5:1]));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        chk("R1 vl in reset", 64'(vl_o), 64'd1);
        chk("R1 mvl in reset", 64'(mvl_o), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vl", 64'(vl_o), 64'd1);
        chk("R1 mvl", 64'(mvl_o), 64'd1);
        chk("R1 wb_req", 64'(wb_req), 64'd0);
        chk("R1 illegal", 64'(illegal), 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] e;
            e = VEC[i];
            issue(e[46:35], XLEN'(e[34:19]), 1'b1);
            chk("R3-R7 vector vl", 64'(vl_o), 64'(e[18:13]));
            chk("R3-R7 vector mvl", 64'(mvl_o), 64'(e[12:7]));
            chk("R8 wb_req", 64'(wb_req), 64'(e[6]));
            if (e[6]) begin
                chk("R8 wb_idx", 64'(wb_idx), 64'(e[5:1]));
                chk("R8 wb_data", wb_data, 64'(e[18:13]));
            end
            chk("R5 illegal", 64'(illegal), 64'(e[0]));
            @(negedge clk);
            chk("R8 wb pulse ends", 64'(wb_req), 64'd0);
            chk("R5 illegal pulse ends", 64'(illegal), 64'd0);
        end

        // State now VL=1, MVL=1. Grow MVL to 20 with one-off.
        issue({1'b1, 5'd0, 5'd19, 1'b0}, '0, 1'b1);
        chk("R6 setup vl", 64'(vl_o), 64'd20);
        // R4: wide source, small low bits, must cap at MVL (20), not load 3
        issue({1'b0, 5'd4, 5'd2, 1'b1}, 64'h0000_0001_0000_0003, 1'b1);
        chk("R4 wide src capped", 64'(vl_o), 64'd20);
        chk("R8 wide src wb_data", wb_data, 64'd20);
        // R9: strobe low, nonzero field ignored
        issue({1'b1, 5'd3, 5'd2, 1'b0}, '0, 1'b0);
        chk("R9 idle vl", 64'(vl_o), 64'd20);
        chk("R9 idle mvl", 64'(mvl_o), 64'd20);
        chk("R9 idle wb_req", 64'(wb_req), 64'd0);
        chk("R9 idle illegal", 64'(illegal), 64'd0);
        // R9: timing - before the edge the old value is still shown
        @(negedge clk);
        len_ctrl  = {1'b0, 5'd0, 5'd4, 1'b0};
        req_valid = 1'b1;
        #1;
        chk("R9 no early update", 64'(vl_o), 64'd20);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 update after edge", 64'(vl_o), 64'd5);
        // R1: reset mid-run restores 1/1
        rst_n = 1'b0;
        #3;
        chk("R1 async reset vl", 64'(vl_o), 64'd1);
        chk("R1 async reset mvl", 64'(mvl_o), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule